// File: doc/BRIEF.md
# Punctured Rate-2/3 Convolutional Encoder

This block feeds one data bit per accepted cycle into a constraint-length-8 convolutional encoder. The encoder has two output branches, so the mother code has rate 1/2. A puncturing stage then drops one of every four coded bits, which gives a rate-2/3 stream. The generator polynomials and the per-phase keep masks are parameters. The encoder register and the puncture phase both return to zero at reset.

The `dual_mode` pin selects one of two output formats, and it is held steady while the block is out of reset:

- **Serial mode** sends one coded bit per valid cycle. An input at puncture phase 0 yields two bits, so the block spends one cycle in a flush state and holds off input while it does.
- **Dual mode** sends two-bit symbols. Input may arrive every cycle, and the output strobe fires on three cycles out of every four accepted inputs.

Control is a two-state machine:

- **ST_ACCEPT** takes input. A phase-0 bit taken in serial mode moves the machine to ST_EXTRA.
- **ST_EXTRA** emits the stashed branch-B bit with input held off, then returns to ST_ACCEPT.

In dual mode the machine never leaves ST_ACCEPT. A single pending-bit register packs the kept bits into symbols.

Top module: `punct_conv_enc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1. The encoder history and the puncture phase start at zero.
- R2: For an accepted bit, branch A equals the XOR of (GEN_A AND w) and branch B equals the XOR of (GEN_B AND w). Here w is an 8-bit window: bit 0 is the current input and bit k is the input accepted k bits earlier. Defaults: GEN_A = 8'b11111001 and GEN_B = 8'b10100111.
- R3: The puncture phase alternates 0, 1, 0, … and advances only on an accepted input (`in_valid` and `in_ready` both high). Phase 0 keeps branch A and then branch B. Phase 1 keeps branch A only.
- R4: In serial mode the kept bits appear on `out_data[0]` one per valid cycle, in the order they were kept. `out_data[1]` is 0 whenever `out_valid` is high.
- R5: In serial mode, accepting a phase-0 bit drives `in_ready` low for exactly the next cycle. Data offered in that cycle is ignored and does not enter the encoder.
- R6: In dual mode `in_ready` is always 1. Each symbol carries the earlier kept bit in `out_data[0]` and the later one in `out_data[1]`.
- R7: In dual mode, numbering accepted inputs k = 0, 1, 2, … from reset, a symbol follows input k unless k mod 4 = 1. Four inputs therefore give three symbols.
- R8: Outputs are registered. A symbol or bit appears in the cycle after the acceptance that completes it. In serial mode the stashed second bit follows one cycle later.
- R9: Cycles with `in_valid` low change neither the encoder history nor the phase. A stream with gaps produces the same coded bits as the same stream without them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dual_mode | input | 1 | 0 = serial one-bit output, 1 = two-bit symbols; static outside reset |
| in_valid | input | 1 | Input bit offered |
| in_bit | input | 1 | Data bit to encode |
| in_ready | output | 1 | Block will take the offered bit this cycle |
| out_valid | output | 1 | `out_data` holds coded output |
| out_data | output | 2 | Coded bit (serial, bit 0) or symbol (dual) |

## Verification
The hardest cases to reach are those where the serial hold-off and the dual-mode pending bit interact with idle gaps. Examples are a bit offered while `in_ready` is low, and a gap that falls between a held bit and the input that completes its symbol.

The stimulus holds `in_valid` high through the serial flush cycles and scatters gaps at every phase. It also runs long pseudo-random streams, so the pending bit meets gaps at both phases. An independent bench model follows only accepted bits. Every output bit and every strobe is compared against that model.

// File: rtl/punct_conv_pkg.sv
package punct_conv_pkg;
    typedef enum logic {
        ST_ACCEPT = 1'b0,
        ST_EXTRA  = 1'b1
    } pce_state_e;

    localparam int DEF_CL   = 8;
    localparam int DEF_PLEN = 2;
endpackage

// File: rtl/pce_shift.sv
module pce_shift #(
    parameter int                         CL     = 8,
    parameter logic [1:0][CL-1:0]         GENS   = {8'b10100111, 8'b11111001}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       shift_en,
    input  logic       din,
    output logic [1:0] code
);
    localparam int MW = CL - 1;

    logic [MW-1:0] hist_q;
    logic [CL-1:0] window;

    // bit 0 is the current input, bit k the input accepted k bits ago
    assign window = {hist_q, din};

    for (genvar b = 0; b < 2; b++) begin : g_branch
        assign code[b] = ^(GENS[b] & window);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (shift_en)
            hist_q <= window[MW-1:0];
    end
endmodule

// File: rtl/pce_phase.sv
module pce_phase #(
    parameter int PLEN = 2,
    localparam int PW  = (PLEN > 1) ? $clog2(PLEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [PW-1:0] phase
);
    localparam logic [PW-1:0] LAST = PW'(PLEN - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (step)
            phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
endmodule

// File: rtl/punct_conv_enc.sv
module punct_conv_enc
    import punct_conv_pkg::*;
#(
    parameter int              CL     = DEF_CL,
    parameter int              PLEN   = DEF_PLEN,
    parameter logic [CL-1:0]   GEN_A  = 8'b11111001,
    parameter logic [CL-1:0]   GEN_B  = 8'b10100111,
    parameter logic [PLEN-1:0] KEEP_A = 2'b11,
    parameter logic [PLEN-1:0] KEEP_B = 2'b01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dual_mode,
    input  logic       in_valid,
    input  logic       in_bit,
    output logic       in_ready,
    output logic       out_valid,
    output logic [1:0] out_data
);
    localparam int PW = (PLEN > 1) ? $clog2(PLEN) : 1;

    pce_state_e    state_q, state_d;
    logic [PW-1:0] phase_q;
    logic [1:0]    code;
    logic          accept;
    logic          keep_a, keep_b;
    logic [1:0]    new_bits;
    logic [1:0]    new_cnt;
    logic          stash_q, stash_d;
    logic          hold_q, hold_d;
    logic          hold_v_q, hold_v_d;
    logic          ov_d;
    logic [1:0]    od_d;

    assign in_ready = dual_mode || (state_q == ST_ACCEPT);
    assign accept   = in_valid && in_ready;
    assign keep_a   = KEEP_A[phase_q];
    assign keep_b   = KEEP_B[phase_q];

    pce_shift #(.CL(CL), .GENS({GEN_B, GEN_A})) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (in_bit),
        .code     (code)
    );

    pce_phase #(.PLEN(PLEN)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accept),
        .phase (phase_q)
    );

    // surviving bits of the current codeword, earliest in bit 0
    always_comb begin
        new_bits = 2'b00;
        new_cnt  = 2'd0;
        if (keep_a && keep_b) begin
            new_bits = code;
            new_cnt  = 2'd2;
        end else if (keep_a) begin
            new_bits = {1'b0, code[0]};
            new_cnt  = 2'd1;
        end else if (keep_b) begin
            new_bits = {1'b0, code[1]};
            new_cnt  = 2'd1;
        end
    end

    // next state and next outputs
    always_comb begin
        state_d  = state_q;
        stash_d  = stash_q;
        hold_d   = hold_q;
        hold_v_d = hold_v_q;
        ov_d     = 1'b0;
        od_d     = 2'b00;
        if (!dual_mode) begin
            unique case (state_q)
                ST_ACCEPT: begin
                    if (accept && new_cnt != 2'd0) begin
                        ov_d = 1'b1;
                        od_d = {1'b0, new_bits[0]};
                        if (new_cnt == 2'd2) begin
                            stash_d = new_bits[1];
                            state_d = ST_EXTRA;
                        end
                    end
                end
                ST_EXTRA: begin
                    ov_d    = 1'b1;
                    od_d    = {1'b0, stash_q};
                    state_d = ST_ACCEPT;
                end
            endcase
        end else if (accept) begin
            if (hold_v_q) begin
                if (new_cnt != 2'd0) begin
                    ov_d     = 1'b1;
                    od_d     = {new_bits[0], hold_q};
                    hold_v_d = (new_cnt == 2'd2);
                    hold_d   = new_bits[1];
                end
            end else if (new_cnt == 2'd2) begin
                ov_d = 1'b1;
                od_d = new_bits;
            end else if (new_cnt == 2'd1) begin
                hold_d   = new_bits[0];
                hold_v_d = 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_ACCEPT;
            stash_q  <= 1'b0;
            hold_q   <= 1'b0;
            hold_v_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            stash_q  <= stash_d;
            hold_q   <= hold_d;
            hold_v_q <= hold_v_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= 2'b00;
        end else begin
            out_valid <= ov_d;
            out_data  <= od_d;
        end
    end
endmodule

// File: rtl/punct_conv_chk.sv
module punct_conv_chk #(
    parameter int PW = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dual_mode,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic [1:0]    out_data,
    input logic [PW-1:0] phase,
    input logic          hold_v
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable(phase));

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (phase != $past(phase)));

    // R5
    ser_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && in_valid && in_ready && phase == '0) |=> !in_ready);

    // R4
    ser_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_mode && out_valid) |-> !out_data[1]);

    // R6
    dual_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dual_mode |-> in_ready);

    // R7
    dual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_mode && in_valid && in_ready && phase != '0 && !hold_v) |=> !out_valid);

    // R8
    dual_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_mode && out_valid) |-> $past(in_valid && in_ready));
endmodule

bind punct_conv_enc punct_conv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dual_mode (dual_mode),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .phase     (phase_q),
    .hold_v    (hold_v_q)
);

// File: tb/punct_conv_enc_tb.sv
module punct_conv_enc_tb;
    localparam logic [7:0] GA = 8'b11111001;
    localparam logic [7:0] GB = 8'b10100111;
    localparam int NV = 40;
    // entries: {dual_mode, in_valid, in_bit}
    localparam logic [2:0] VEC [NV] = '{
        3'b011, 3'b011, 3'b010, 3'b011, 3'b000, 3'b010, 3'b011, 3'b011,
        3'b001, 3'b010, 3'b011, 3'b010, 3'b010, 3'b011, 3'b000, 3'b011,
        3'b011, 3'b010, 3'b011, 3'b010,
        3'b111, 3'b110, 3'b111, 3'b111, 3'b111, 3'b110, 3'b110, 3'b111,
        3'b100, 3'b111, 3'b110, 3'b111, 3'b111, 3'b111, 3'b101, 3'b110,
        3'b111, 3'b110, 3'b110, 3'b111
    };

    logic       clk = 1'b0;
    logic       rst_n, dual_mode, in_valid, in_bit;
    logic       in_ready, out_valid;
    logic [1:0] out_data;

    always #10 clk = ~clk;

    punct_conv_enc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dual_mode (dual_mode),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    int       checks = 0;
    int       fails  = 0;
    bit       done   = 0;
    bit       exp_q [$];
    logic [6:0] m_hist;
    bit       m_ph;
    int       acc_cnt;
    bit       acc_prev;
    int       acc_prev_idx;
    bit       extra_pend;
    bit       low_prev;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_push(input bit b);
        logic [7:0] w;
        w = {m_hist, b};
        exp_q.push_back(^(GA & w));
        if (!m_ph) exp_q.push_back(^(GB & w));
        m_hist = w[6:0];
        m_ph   = ~m_ph;
    endtask

    task automatic monitor();
        bit e0, e1, ev;
        if (!dual_mode) begin
            check(in_ready == !extra_pend, "R5 in_ready", int'(in_ready), int'(!extra_pend));
            ev = acc_prev || low_prev;
            check(out_valid == ev, "R8 serial out_valid", int'(out_valid), int'(ev));
            low_prev = extra_pend;
            if (out_valid) begin
                e0 = exp_q.size() > 0 ? exp_q.pop_front() : 1'b0;
                check(out_data[0] == e0, "R2/R4 serial bit", int'(out_data[0]), int'(e0));
                check(out_data[1] == 1'b0, "R4 serial upper bit", int'(out_data[1]), 0);
            end
        end else begin
            check(in_ready == 1'b1, "R6 in_ready", int'(in_ready), 1);
            ev = acc_prev && (acc_prev_idx % 4 != 1);
            check(out_valid == ev, "R7 strobe cadence", int'(out_valid), int'(ev));
            if (out_valid && exp_q.size() >= 2) begin
                e0 = exp_q.pop_front();
                e1 = exp_q.pop_front();
                check(out_data == {e1, e0}, "R2/R6 symbol", int'(out_data), int'({e1, e0}));
            end
        end
    endtask

    // called at a falling edge
    task automatic step(input bit v, input bit b);
        bit will_acc;
        monitor();
        in_valid = v;
        in_bit   = b;
        will_acc = v && in_ready;
        extra_pend = !dual_mode && will_acc && !m_ph;
        acc_prev_idx = acc_cnt;
        if (will_acc) begin
            model_push(b);
            acc_cnt++;
        end
        acc_prev = will_acc;
        @(negedge clk);
    endtask

    task automatic do_reset(input bit m);
        rst_n = 1'b0; dual_mode = m; in_valid = 1'b0; in_bit = 1'b0;
        repeat (2) @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        rst_n = 1'b1;
        m_hist = '0; m_ph = 1'b0; exp_q.delete();
        acc_cnt = 0; acc_prev = 1'b0; acc_prev_idx = 0;
        extra_pend = 1'b0; low_prev = 1'b0;
    endtask

    task automatic drain();
        repeat (3) step(1'b0, 1'b0);
        if (!dual_mode)
            check(exp_q.size() == 0, "R4 serial stream drained", exp_q.size(), 0);
        else
            check(exp_q.size() <= 1, "R7 dual leftover", exp_q.size(), 1);
    endtask

    task automatic lfsr_run(input bit m, input int n, input logic [15:0] seed);
        logic [15:0] s;
        s = seed;
        do_reset(m);
        for (int i = 0; i < n; i++) begin
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            // R9: gaps at about one cycle in four
            step(s[3:2] != 2'b00, s[0]);
        end
        drain();
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(1'b0);
        for (int i = 0; i < NV; i++) begin
            if (i > 0 && VEC[i][2] != dual_mode) begin
                drain();
                do_reset(VEC[i][2]);
            end
            step(VEC[i][1], VEC[i][0]);
        end
        drain();

        // R2: impulse response in serial mode reproduces the generators
        do_reset(1'b0);
        step(1'b1, 1'b1);
        for (int i = 0; i < 9; i++) step(1'b1, 1'b0);
        drain();

        // R1: reset in the middle of a dual stream
        do_reset(1'b1);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
        do_reset(1'b1);
        for (int i = 0; i < 8; i++) step(1'b1, i[0]);
        drain();

        // R5/R9: long streams with gaps in both modes
        lfsr_run(1'b0, 300, 16'hACE1);
        lfsr_run(1'b1, 300, 16'h3C5A);
        lfsr_run(1'b1, 200, 16'h0F0F);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule